// File: doc/BRIEF.md
# Per-Port Traffic Statistics Bank with Indirect Readback

This block keeps traffic statistics for every port of a small packet switch. Each port owns 32 event counters and 4 dropped-packet counters, so 36 counters per port in all. An event counter is 30 bits wide and a dropped-packet counter is 16 bits wide. Each counter advances by one on every cycle in which its increment strobe is high. Management software never addresses a counter directly. It writes a table code into a select register, then writes a counter index into a trigger register. One cycle later a 40-bit result is latched. The result holds an overflow flag, a valid flag and the count, and software reads it back as five bytes. Reading a counter clears it.

Two host-writable controls act on a whole port. The freeze mask stops a port's counters from advancing. A flush write zeroes every counter of the selected ports in one cycle.

The read sequencer has two states. In IDLE it waits for a trigger write; the transition IDLE to CAPTURE is taken when the trigger register is written. In CAPTURE the selected counter is copied into the result register and cleared, and the valid flag is set if the selection was legal. The transition CAPTURE to IDLE is taken unless a new trigger write arrives in that same cycle. If one does, the transition CAPTURE to CAPTURE is taken and a second capture follows.

Top module: `stat_bank`

## Requirements
- R1: Select code 0x1c picks the event counters and 0x1d picks the dropped-packet counters. After a trigger with any other code, the valid flag stays 0 and all result bits read 0.
- R2: Trigger index bits [7:5] name the port and bits [4:0] name the counter. Event counters use 0..31 and dropped-packet counters use 0..3. A port number at or above the port count, or a counter number out of range, gives valid 0 and a zero result.
- R3: Register addresses 4, 5, 6, 7 and 8 return result bits [39:32], [31:24], [23:16], [15:8] and [7:0] in that order. Bit 39 always reads 0.
- R4: Result bit 37 (valid) reads 0 in the cycle after a trigger write. It reads 1 from the following cycle onward for a legal selection, and it keeps its value until the next trigger write.
- R5: An event result carries its count in bits [29:0] with bits [36:30] zero. A dropped-packet result carries its count in bits [15:0] with bits [36:16] zero.
- R6: Capturing a counter zeroes its count and its overflow flag.
- R7: An increment that lands in the capture cycle is kept, so the counter restarts at 1.
- R8: A counter that passes its maximum wraps to 0 and sets a sticky overflow flag, reported in result bit 38.
- R9: Address 2 holds the freeze mask, bit p for port p, and can be read back. While bit p is set, increments on port p are ignored; other ports keep counting.
- R10: Writing address 3 with bit p set zeroes every counter and overflow flag of port p. Address 3 reads as 0.
- R11: After reset, the select, trigger and freeze registers and all result bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_inc | input | 160 | Event increment strobes, bit p*32+c for port p counter c |
| drp_inc | input | 20 | Dropped-packet increment strobes, bit p*4+c |
| host_we | input | 1 | Host register write enable |
| host_waddr | input | 4 | Host write address |
| host_wdata | input | 8 | Host write data |
| host_raddr | input | 4 | Host read address |
| host_rdata | output | 8 | Host read data (combinational) |

## Verification
The bound checker tests the read sequencer on every cycle. It checks that valid drops after a trigger and rises after a legal capture. It checks that an illegal selection leaves an all-zero invalid result, and that valid holds between triggers. It also checks that bit 39 and the unused field bits of each table stay zero. Counter arithmetic can only be shown through the bench's scenarios: clear on read, an increment in the capture cycle, wrap with a sticky overflow, freeze isolation between ports, and flush. Those scenarios drive exact strobe counts and then compare the bytes read back.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam logic [7:0] TBL_EVT  = 8'h1c;
    localparam logic [7:0] TBL_DRP  = 8'h1d;

    localparam logic [3:0] RA_TBL   = 4'd0;
    localparam logic [3:0] RA_TRIG  = 4'd1;
    localparam logic [3:0] RA_FRZ   = 4'd2;
    localparam logic [3:0] RA_FLUSH = 4'd3;
    localparam logic [3:0] RA_RB4   = 4'd4;
    localparam logic [3:0] RA_RB3   = 4'd5;
    localparam logic [3:0] RA_RB2   = 4'd6;
    localparam logic [3:0] RA_RB1   = 4'd7;
    localparam logic [3:0] RA_RB0   = 4'd8;

    localparam int RES_W = 40;
    localparam int VAL_W = 37;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_CAPTURE = 1'b1
    } rd_state_t;
endpackage

// File: rtl/stat_cell.sv
module stat_cell #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         hold,
    input  logic         flush,
    input  logic         rclr,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] base;
    logic         ovf_base;
    logic [W:0]   sum;

    // A capture clears the old value, but an increment in the same cycle is kept
    always_comb begin
        base     = rclr ? '0 : cnt;
        ovf_base = rclr ? 1'b0 : ovf;
        sum      = {1'b0, base} + {{W{1'b0}}, (inc && !hold)};
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else begin
            cnt <= sum[W-1:0];
            ovf <= ovf_base | sum[W];
        end
    end
endmodule

// File: rtl/stat_rd_fsm.sv
module stat_rd_fsm
    import stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_wr,
    input  logic hit,
    output logic capture,
    output logic valid
);
    rd_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (trig_wr) st_nx = ST_CAPTURE;
            ST_CAPTURE: st_nx = trig_wr ? ST_CAPTURE : ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    assign capture = (st == ST_CAPTURE);

    always_ff @(posedge clk) begin
        if (!rst_n)       valid <= 1'b0;
        else if (trig_wr) valid <= 1'b0;
        else if (capture) valid <= hit;
    end
endmodule

// File: rtl/stat_bank.sv
module stat_bank
    import stat_pkg::*;
#(
    parameter int NUM_PORTS    = 5,
    parameter int EVT_PER_PORT = 32,
    parameter int DRP_PER_PORT = 4,
    parameter int EVT_W        = 30,
    parameter int DRP_W        = 16,
    parameter int PORT_LSB     = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_PORTS*EVT_PER_PORT-1:0] evt_inc,
    input  logic [NUM_PORTS*DRP_PER_PORT-1:0] drp_inc,
    input  logic                              host_we,
    input  logic [3:0]                        host_waddr,
    input  logic [7:0]                        host_wdata,
    input  logic [3:0]                        host_raddr,
    output logic [7:0]                        host_rdata
);
    localparam int NEV  = NUM_PORTS * EVT_PER_PORT;
    localparam int NDR  = NUM_PORTS * DRP_PER_PORT;
    localparam int PF_W = 8 - PORT_LSB;

    logic [7:0]           tbl_q, idx_q;
    logic [NUM_PORTS-1:0] frz_q, flush_vec;
    logic                 trig_wr, capture, valid, hit, hit_evt, hit_drp, port_ok;
    logic [PF_W-1:0]      port_f;
    logic [PORT_LSB-1:0]  cnt_f;

    logic [EVT_W-1:0]     evt_cnt [NEV];
    logic [NEV-1:0]       evt_ovf, evt_clr;
    logic [DRP_W-1:0]     drp_cnt [NDR];
    logic [NDR-1:0]       drp_ovf, drp_clr;

    logic [VAL_W-1:0]     sel_val;
    logic                 sel_ovf;
    logic [RES_W-1:0]     res_q;

    // Host-writable registers
    assign trig_wr   = host_we && (host_waddr == RA_TRIG);
    assign flush_vec = (host_we && host_waddr == RA_FLUSH) ? host_wdata[NUM_PORTS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
            idx_q <= '0;
            frz_q <= '0;
        end else if (host_we) begin
            if (host_waddr == RA_TBL)  tbl_q <= host_wdata;
            if (host_waddr == RA_TRIG) idx_q <= host_wdata;
            if (host_waddr == RA_FRZ)  frz_q <= host_wdata[NUM_PORTS-1:0];
        end
    end

    // Index decode
    assign port_f  = idx_q[7:PORT_LSB];
    assign cnt_f   = idx_q[PORT_LSB-1:0];
    assign port_ok = int'(port_f) < NUM_PORTS;
    assign hit_evt = (tbl_q == TBL_EVT) && port_ok && (int'(cnt_f) < EVT_PER_PORT);
    assign hit_drp = (tbl_q == TBL_DRP) && port_ok && (int'(cnt_f) < DRP_PER_PORT);
    assign hit     = hit_evt || hit_drp;

    stat_rd_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_wr (trig_wr),
        .hit     (hit),
        .capture (capture),
        .valid   (valid)
    );

    // Counter arrays
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar c = 0; c < EVT_PER_PORT; c++) begin : g_evt
            localparam int I = p * EVT_PER_PORT + c;
            assign evt_clr[I] = capture && hit_evt &&
                                (port_f == PF_W'(p)) && (cnt_f == PORT_LSB'(c));
            stat_cell #(.W(EVT_W)) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (evt_inc[I]),
                .hold  (frz_q[p]),
                .flush (flush_vec[p]),
                .rclr  (evt_clr[I]),
                .cnt   (evt_cnt[I]),
                .ovf   (evt_ovf[I])
            );
        end
        for (genvar c = 0; c < DRP_PER_PORT; c++) begin : g_drp
            localparam int J = p * DRP_PER_PORT + c;
            assign drp_clr[J] = capture && hit_drp &&
                                (port_f == PF_W'(p)) && (cnt_f == PORT_LSB'(c));
            stat_cell #(.W(DRP_W)) u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .inc   (drp_inc[J]),
                .hold  (frz_q[p]),
                .flush (flush_vec[p]),
                .rclr  (drp_clr[J]),
                .cnt   (drp_cnt[J]),
                .ovf   (drp_ovf[J])
            );
        end
    end

    // The clear strobes are one-hot during capture, so they double as the mux select
    always_comb begin
        sel_val = '0;
        sel_ovf = 1'b0;
        for (int i = 0; i < NEV; i++) begin
            if (evt_clr[i]) begin
                sel_val = sel_val | VAL_W'(evt_cnt[i]);
                sel_ovf = sel_ovf | evt_ovf[i];
            end
        end
        for (int j = 0; j < NDR; j++) begin
            if (drp_clr[j]) begin
                sel_val = sel_val | VAL_W'(drp_cnt[j]);
                sel_ovf = sel_ovf | drp_ovf[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       res_q <= '0;
        else if (capture) res_q <= {1'b0, sel_ovf, 1'b0, sel_val};
    end

    // Readback
    always_comb begin
        unique case (host_raddr)
            RA_TBL:  host_rdata = tbl_q;
            RA_TRIG: host_rdata = idx_q;
            RA_FRZ:  host_rdata = 8'(frz_q);
            RA_RB4:  host_rdata = {res_q[39:38], valid, res_q[36:32]};
            RA_RB3:  host_rdata = res_q[31:24];
            RA_RB2:  host_rdata = res_q[23:16];
            RA_RB1:  host_rdata = res_q[15:8];
            RA_RB0:  host_rdata = res_q[7:0];
            default: host_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk
    import stat_pkg::*;
#(
    parameter int EVT_W = 30,
    parameter int DRP_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_wr,
    input logic             capture,
    input logic             valid,
    input logic             hit,
    input logic [7:0]       tbl_q,
    input logic [RES_W-1:0] res_q
);
    // R4
    trig_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr |=> (!valid && capture));

    // R4
    cap_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !trig_wr && hit) |=> valid);

    // R4
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig_wr && !capture) |=> $stable(valid));

    // R1
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !trig_wr && !hit) |=> (!valid && res_q == '0));

    // R3
    top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_q[39] == 1'b0);

    // R5
    evt_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && tbl_q == TBL_EVT) |=> (res_q[36:EVT_W] == '0));

    // R5
    drp_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && tbl_q == TBL_DRP) |=> (res_q[36:DRP_W] == '0));
endmodule

bind stat_bank stat_bank_chk #(.EVT_W(EVT_W), .DRP_W(DRP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_wr (trig_wr),
    .capture (capture),
    .valid   (valid),
    .hit     (hit),
    .tbl_q   (tbl_q),
    .res_q   (res_q)
);

// File: tb/sim_stat_bank.sv
module sim_stat_bank;
    localparam int NP = 5, NE = 32, ND = 4;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_NOP = 2'd2;
    localparam int NVEC = 27;
    // {op, addr, data, expected}
    localparam logic [21:0] VEC [NVEC] = '{
        {OP_RD,  4'd0, 8'h00, 8'h00},  // R11
        {OP_RD,  4'd1, 8'h00, 8'h00},  // R11
        {OP_RD,  4'd2, 8'h00, 8'h00},  // R11
        {OP_RD,  4'd4, 8'h00, 8'h00},  // R11
        {OP_RD,  4'd8, 8'h00, 8'h00},  // R11
        {OP_WR,  4'd0, 8'h1c, 8'h00},
        {OP_RD,  4'd0, 8'h00, 8'h1c},  // R1
        {OP_WR,  4'd1, 8'h00, 8'h00},
        {OP_NOP, 4'd0, 8'h00, 8'h00},
        {OP_RD,  4'd4, 8'h00, 8'h20},  // R3 R4
        {OP_RD,  4'd8, 8'h00, 8'h00},  // R3
        {OP_WR,  4'd0, 8'h55, 8'h00},
        {OP_WR,  4'd1, 8'h00, 8'h00},
        {OP_NOP, 4'd0, 8'h00, 8'h00},
        {OP_RD,  4'd4, 8'h00, 8'h00},  // R1 bad code
        {OP_WR,  4'd0, 8'h1c, 8'h00},
        {OP_WR,  4'd1, 8'ha0, 8'h00},
        {OP_NOP, 4'd0, 8'h00, 8'h00},
        {OP_RD,  4'd4, 8'h00, 8'h00},  // R2 port 5 absent
        {OP_WR,  4'd0, 8'h1d, 8'h00},
        {OP_WR,  4'd1, 8'h04, 8'h00},
        {OP_NOP, 4'd0, 8'h00, 8'h00},
        {OP_RD,  4'd4, 8'h00, 8'h00},  // R2 drop index 4 absent
        {OP_WR,  4'd2, 8'h15, 8'h00},
        {OP_RD,  4'd2, 8'h00, 8'h15},  // R9 readback
        {OP_WR,  4'd2, 8'h00, 8'h00},
        {OP_RD,  4'd3, 8'h00, 8'h00}   // R10 reads zero
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP*NE-1:0]  evt_inc = '0;
    logic [NP*ND-1:0]  drp_inc = '0;
    logic              host_we = 1'b0;
    logic [3:0]        host_waddr = '0;
    logic [7:0]        host_wdata = '0;
    logic [3:0]        host_raddr = '0;
    logic [7:0]        host_rdata;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    stat_bank u0 (
        .clk(clk), .rst_n(rst_n), .evt_inc(evt_inc), .drp_inc(drp_inc),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rdb(input logic [3:0] a, output logic [7:0] d);
        host_raddr = a;
        #1 d = host_rdata;
    endtask

    task automatic rd_res(output logic [39:0] r);
        logic [7:0] b;
        for (int k = 0; k < 5; k++) begin
            rdb(4'(4 + k), b);
            r = {r[31:0], b};
        end
    endtask

    task automatic cap(input logic [7:0] t, input logic [7:0] idx, output logic [39:0] r);
        wr(4'd0, t);
        wr(4'd1, idx);
        @(negedge clk);
        rd_res(r);
    endtask

    task automatic pulse_evt(input int i, input int n);
        @(negedge clk);
        evt_inc[i] = 1'b1;
        repeat (n) @(negedge clk);
        evt_inc[i] = 1'b0;
    endtask

    task automatic pulse_drp(input int i, input int n);
        @(negedge clk);
        drp_inc[i] = 1'b1;
        repeat (n) @(negedge clk);
        drp_inc[i] = 1'b0;
    endtask

    initial begin
        logic [39:0] r;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            logic [3:0] a;
            logic [7:0] d, e;
            {op, a, d, e} = VEC[i];
            if (op == OP_WR) wr(a, d);
            else if (op == OP_NOP) @(negedge clk);
            else begin
                rdb(a, b);
                chk($sformatf("R1-vector %0d addr %0d", i, a), {32'h0, b}, {32'h0, e});
            end
        end

        // R4: valid low right after the trigger, high one cycle later
        wr(4'd0, 8'h1c);
        @(negedge clk);
        host_we = 1'b1; host_waddr = 4'd1; host_wdata = 8'h00;
        @(negedge clk);
        host_we = 1'b0;
        rdb(4'd4, b);
        chk("R4 valid after trigger", {32'h0, b}, 40'h00);
        @(negedge clk);
        rdb(4'd4, b);
        chk("R4 valid after capture", {32'h0, b}, 40'h20);
        repeat (3) @(negedge clk);
        rdb(4'd4, b);
        chk("R4 valid held", {32'h0, b}, 40'h20);

        // R5 R6: event counter port 1 index 13 (trigger 0x2d)
        pulse_evt(1*NE + 13, 3);
        cap(8'h1c, 8'h2d, r);
        chk("R5 event count", r, 40'h20_0000_0003);
        cap(8'h1c, 8'h2d, r);
        chk("R6 cleared by read", r, 40'h20_0000_0000);

        // R5: dropped-packet counter port 0 index 1
        pulse_drp(0*ND + 1, 5);
        cap(8'h1d, 8'h01, r);
        chk("R5 drop count", r, 40'h20_0000_0005);

        // R9: freeze port 2 only
        wr(4'd2, 8'h04);
        pulse_evt(2*NE + 0, 4);
        pulse_evt(0*NE + 0, 2);
        cap(8'h1c, 8'h40, r);
        chk("R9 frozen port ignored", r, 40'h20_0000_0000);
        cap(8'h1c, 8'h00, r);
        chk("R9 other port counts", r, 40'h20_0000_0002);
        wr(4'd2, 8'h00);

        // R10: flush port 3
        pulse_evt(3*NE + 5, 5);
        wr(4'd3, 8'h08);
        cap(8'h1c, 8'h65, r);
        chk("R10 flushed", r, 40'h20_0000_0000);

        // R7: increment during the capture cycle
        pulse_evt(4*NE + 2, 2);
        wr(4'd0, 8'h1c);
        @(negedge clk);
        host_we = 1'b1; host_waddr = 4'd1; host_wdata = 8'h82;
        @(negedge clk);
        host_we = 1'b0;
        evt_inc[4*NE + 2] = 1'b1;
        @(negedge clk);
        evt_inc[4*NE + 2] = 1'b0;
        rd_res(r);
        chk("R7 value before clear", r, 40'h20_0000_0002);
        cap(8'h1c, 8'h82, r);
        chk("R7 restart at one", r, 40'h20_0000_0001);

        // R8: dropped-packet counter port 1 index 3 wraps
        pulse_drp(1*ND + 3, 65537);
        cap(8'h1d, 8'h23, r);
        chk("R8 overflow flag and wrap", r, 40'h60_0000_0001);
        cap(8'h1d, 8'h23, r);
        chk("R6 overflow cleared", r, 40'h20_0000_0000);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule